// File: doc/BRIEF.md
# Configurable Quadrature Pulse Counter

This block turns pulses on two sense inputs, `s0` and `s1`, into signed counting events and accumulates them in a main counter and an auxiliary counter. A control register selects one of four operating modes. The block can be disabled. It can count `s0` pulses through a glitch filter, or count raw `s0` pulses; in both single-input modes the direction comes from `s1` or from a control bit. It can also decode two phase-shifted signals, taking direction from `s1` and rate from `s0`.

The main counter runs between zero and a programmable top value. It wraps at either end and raises an overflow or underflow flag. The next top value can be staged in a buffer and takes effect at the next wrap or on command. Each counter has its own event filter. A hysteresis option drops the first event after a change of direction, which suppresses chatter on a shaft that is standing still. Software reaches everything through a flat register port: a synchronous write strobe and a combinational read.

Top module: `quad_pulse_counter`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x74: mode field [1:0]=0 (disabled), main event select [3:2]=1 (up only), aux event select [5:4]=3 (none), bit 6 (direction from `s1`)=1, bit 7 (software down)=0, bit 8 (hysteresis)=0. CNT (1) and AUXCNT (2) read 0, TOP (3) and TOPB (4) read all ones, flags (5) and `irq` read 0.
- R2: In mode 0 (disabled), no `s0` activity changes CNT, AUXCNT or the flags.
- R3: In the single-input modes an event is a rising edge of `s0`, and its direction is down when `s1` is high (if CTRL bit 6 is 1) or when CTRL bit 7 is 1 (if bit 6 is 0). Mode 2 (external single) counts an `s0` pulse one clock long. Mode 1 (oversampled single) counts an edge only once `s0` has held a level for FILT_LEN consecutive samples (default 3), so a one-clock pulse is not counted.
- R4: In mode 3 (quadrature), each rising edge of `s0` is an event whose direction is up when `s1` is low and down when `s1` is high.
- R5: The main event select encodes 0 = count up on up events and down on down events, 1 = count up on up events only, 2 = count down on down events only, 3 = ignore all events.
- R6: AUXCNT increments by one for each event that its own select, with the same encoding as R5, accepts. It is independent of the main select.
- R7: An accepted up event with CNT equal to TOP sets CNT to 0 and sets flag bit 0 (overflow). Any other accepted up event adds one.
- R8: An accepted down event with CNT equal to 0 loads CNT with the TOPB value that becomes TOP at that wrap, and sets flag bit 1 (underflow).
- R9: A write to TOP sets both TOP and TOPB. A write to TOPB only stages the value. TOPB moves into TOP at every overflow or underflow and when bit 1 is written to the command address 9.
- R10: Writing bit 0 to the command address 9 clears CNT, AUXCNT and TOP. This takes precedence over events and over a simultaneous load.
- R11: Writing 1 to a bit of address 6 sets the matching flag, and writing 1 to a bit of address 7 clears it. `irq` equals the flags ANDed bit by bit with the enable mask at address 8.
- R12: With CTRL bit 8 set, an event whose direction differs from that of the previous event is dropped by both counters. The next event in the new direction counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Register write strobe |
| waddr | input | ADDR_W | Register write address |
| wdata | input | DATA_W | Register write data |
| raddr | input | ADDR_W | Register read address |
| rdata | output | DATA_W | Read data, combinational from `raddr` |
| s0 | input | 1 | Count input (pulse or quadrature phase A) |
| s1 | input | 1 | Direction input (level or quadrature phase B) |
| irq | output | 2 | Enabled pending flags: bit 0 overflow, bit 1 underflow |

## Verification
The assertions check four things on every cycle: the counters hold still while disabled, AUXCNT never moves by more than one, a counted step at TOP or at zero always wraps and raises its flag in the next cycle, and the clear command and the flag-clear write take effect one cycle later. Only the bench scenarios can show the points that depend on pulse history. These are the glitch filter that rejects a one-clock pulse, the direction taken from `s1` in each mode, the dropping of the first event after a reversal under hysteresis, and the postponing of a staged TOPB value until the wrap that consumes it.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_OVS  = 2'd1,
        MODE_EXT  = 2'd2,
        MODE_QUAD = 2'd3
    } qpc_mode_e;

    typedef enum logic [1:0] {
        EV_BOTH = 2'd0,
        EV_UP   = 2'd1,
        EV_DOWN = 2'd2,
        EV_NONE = 2'd3
    } qpc_evsel_e;

    typedef struct packed {
        logic       hyst;
        logic       soft_down;
        logic       dir_pin;
        qpc_evsel_e aux_ev;
        qpc_evsel_e main_ev;
        qpc_mode_e  mode;
    } qpc_ctrl_t;

    localparam int CTRL_W = $bits(qpc_ctrl_t);

    localparam qpc_ctrl_t CTRL_RST = '{
        hyst: 1'b0, soft_down: 1'b0, dir_pin: 1'b1,
        aux_ev: EV_NONE, main_ev: EV_UP, mode: MODE_OFF
    };

    typedef struct packed {
        logic valid;
        logic down;
    } qpc_event_t;

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CNT  = 4'd1;
    localparam logic [3:0] A_AUX  = 4'd2;
    localparam logic [3:0] A_TOP  = 4'd3;
    localparam logic [3:0] A_TOPB = 4'd4;
    localparam logic [3:0] A_FLAG = 4'd5;
    localparam logic [3:0] A_FSET = 4'd6;
    localparam logic [3:0] A_FCLR = 4'd7;
    localparam logic [3:0] A_IEN  = 4'd8;
    localparam logic [3:0] A_CMD  = 4'd9;

    function automatic logic ev_accepted(qpc_evsel_e sel, logic down);
        case (sel)
            EV_BOTH: ev_accepted = 1'b1;
            EV_UP:   ev_accepted = !down;
            EV_DOWN: ev_accepted = down;
            default: ev_accepted = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/qpc_decode.sv
module qpc_decode import qpc_pkg::*; #(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       s0,
    input  logic       s1,
    input  qpc_mode_e  mode,
    input  logic       dir_pin,
    input  logic       soft_down,
    input  logic       hyst,
    output qpc_event_t ev
);

    logic                s0_q, s0_d, s1_q;
    logic [FILT_LEN-1:0] hist;
    logic                filt, filt_d;
    logic                last_dn;
    logic                rise, dir_dn, raw_valid, drop;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_q    <= 1'b0;
            s0_d    <= 1'b0;
            s1_q    <= 1'b0;
            hist    <= '0;
            filt    <= 1'b0;
            filt_d  <= 1'b0;
            last_dn <= 1'b0;
        end else begin
            s0_q   <= s0;
            s1_q   <= s1;
            s0_d   <= s0_q;
            hist   <= {hist[FILT_LEN-2:0], s0_q};
            if (&hist)
                filt <= 1'b1;
            else if (~|hist)
                filt <= 1'b0;
            filt_d <= filt;
            if (raw_valid)
                last_dn <= dir_dn;
        end
    end

    always_comb begin
        rise      = (mode == MODE_OVS) ? (filt & ~filt_d) : (s0_q & ~s0_d);
        dir_dn    = (mode == MODE_QUAD || dir_pin) ? s1_q : soft_down;
        raw_valid = (mode != MODE_OFF) && rise;
        drop      = hyst && (dir_dn != last_dn);
        ev.valid  = raw_valid && !drop;
        ev.down   = dir_dn;
    end

endmodule

// File: rtl/qpc_count.sv
module qpc_count import qpc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qpc_evsel_e       main_ev,
    input  qpc_evsel_e       aux_ev,
    input  qpc_event_t       ev,
    input  logic             clr,
    input  logic             load,
    input  logic             cnt_we,
    input  logic             top_we,
    input  logic             topb_we,
    input  logic [CNT_W-1:0] wd,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] aux,
    output logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] topb,
    output logic             ovf,
    output logic             unf
);

    logic take_main, take_aux, quiet;

    always_comb begin
        take_main = ev.valid && ev_accepted(main_ev, ev.down);
        take_aux  = ev.valid && ev_accepted(aux_ev, ev.down);
        quiet     = !clr && !cnt_we;
        ovf       = quiet && take_main && !ev.down && (cnt == top);
        unf       = quiet && take_main && ev.down && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            aux  <= '0;
            top  <= '1;
            topb <= '1;
        end else begin
            if (clr)
                cnt <= '0;
            else if (cnt_we)
                cnt <= wd;
            else if (ovf)
                cnt <= '0;
            else if (unf)
                cnt <= topb;
            else if (take_main)
                cnt <= ev.down ? cnt - 1'b1 : cnt + 1'b1;

            if (clr)
                aux <= '0;
            else if (take_aux)
                aux <= aux + 1'b1;

            if (clr)
                top <= '0;
            else if (top_we)
                top <= wd;
            else if (load || ovf || unf)
                top <= topb;

            if (top_we || topb_we)
                topb <= wd;
        end
    end

endmodule

// File: rtl/qpc_flags.sv
module qpc_flags (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] hw_set,
    input  logic [1:0] sw_set,
    input  logic [1:0] sw_clr,
    input  logic       en_we,
    input  logic [1:0] en_wd,
    output logic [1:0] pend,
    output logic [1:0] en,
    output logic [1:0] irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            en   <= '0;
        end else begin
            pend <= (pend & ~sw_clr) | sw_set | hw_set;
            if (en_we)
                en <= en_wd;
        end
    end

    assign irq = pend & en;

endmodule

// File: rtl/quad_pulse_counter.sv
module quad_pulse_counter import qpc_pkg::*; #(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic              s0,
    input  logic              s1,
    output logic [1:0]        irq
);

    qpc_ctrl_t        ctrl_q;
    qpc_event_t       ev;
    logic [CNT_W-1:0] cnt, aux, top, topb;
    logic             ovf, unf, clr;
    logic [1:0]       flags, ien, sw_set, sw_clr;

    function automatic logic hit(logic [ADDR_W-1:0] a, logic [3:0] r);
        return (a == ADDR_W'(r));
    endfunction

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RST;
        else if (we && hit(waddr, A_CTRL))
            ctrl_q <= qpc_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    assign clr    = we && hit(waddr, A_CMD) && wdata[0];
    assign sw_set = (we && hit(waddr, A_FSET)) ? wdata[1:0] : 2'b00;
    assign sw_clr = (we && hit(waddr, A_FCLR)) ? wdata[1:0] : 2'b00;

    qpc_decode #(.FILT_LEN(FILT_LEN)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .s0        (s0),
        .s1        (s1),
        .mode      (ctrl_q.mode),
        .dir_pin   (ctrl_q.dir_pin),
        .soft_down (ctrl_q.soft_down),
        .hyst      (ctrl_q.hyst),
        .ev        (ev)
    );

    qpc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .main_ev (ctrl_q.main_ev),
        .aux_ev  (ctrl_q.aux_ev),
        .ev      (ev),
        .clr     (clr),
        .load    (we && hit(waddr, A_CMD) && wdata[1]),
        .cnt_we  (we && hit(waddr, A_CNT)),
        .top_we  (we && hit(waddr, A_TOP)),
        .topb_we (we && hit(waddr, A_TOPB)),
        .wd      (wdata[CNT_W-1:0]),
        .cnt     (cnt),
        .aux     (aux),
        .top     (top),
        .topb    (topb),
        .ovf     (ovf),
        .unf     (unf)
    );

    qpc_flags u_flg (
        .clk    (clk),
        .rst    (rst),
        .hw_set ({unf, ovf}),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .en_we  (we && hit(waddr, A_IEN)),
        .en_wd  (wdata[1:0]),
        .pend   (flags),
        .en     (ien),
        .irq    (irq)
    );

    always_comb begin
        rdata = '0;
        if (hit(raddr, A_CTRL))
            rdata[CTRL_W-1:0] = ctrl_q;
        else if (hit(raddr, A_CNT))
            rdata[CNT_W-1:0] = cnt;
        else if (hit(raddr, A_AUX))
            rdata[CNT_W-1:0] = aux;
        else if (hit(raddr, A_TOP))
            rdata[CNT_W-1:0] = top;
        else if (hit(raddr, A_TOPB))
            rdata[CNT_W-1:0] = topb;
        else if (hit(raddr, A_FLAG))
            rdata[1:0] = flags;
        else if (hit(raddr, A_IEN))
            rdata[1:0] = ien;
    end

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker import qpc_pkg::*; #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             we,
    input qpc_mode_e        mode,
    input qpc_evsel_e       main_ev,
    input logic             ev_valid,
    input logic             ev_down,
    input logic             clr,
    input logic             ovf,
    input logic [1:0]       sw_set,
    input logic [1:0]       sw_clr,
    input logic [1:0]       flags,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] aux,
    input logic [CNT_W-1:0] top,
    input logic [CNT_W-1:0] topb
);

    logic up_ok, dn_ok;
    assign up_ok = ev_valid && !ev_down && (main_ev == EV_BOTH || main_ev == EV_UP);
    assign dn_ok = ev_valid && ev_down && (main_ev == EV_BOTH || main_ev == EV_DOWN);

    // R2
    a_r2_disabled_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF && !we) |=> ($stable(cnt) && $stable(aux)));

    // R6
    a_r6_aux_single_step: assert property (@(posedge clk) disable iff (rst)
        !we |=> (aux == $past(aux) || aux == $past(aux) + 1'b1));

    // R7
    a_r7_overflow_wrap: assert property (@(posedge clk) disable iff (rst)
        (up_ok && cnt == top && !we) |=> (cnt == '0 && flags[0]));

    // R8
    a_r8_underflow_wrap: assert property (@(posedge clk) disable iff (rst)
        (dn_ok && cnt == '0 && !we) |=> (cnt == $past(topb) && flags[1] && top == $past(topb)));

    // R10
    a_r10_clear_cmd: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0 && aux == '0 && top == '0));

    // R11
    a_r11_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (sw_clr[0] && !sw_set[0] && !ovf) |=> !flags[0]);

endmodule

bind quad_pulse_counter qpc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .mode     (ctrl_q.mode),
    .main_ev  (ctrl_q.main_ev),
    .ev_valid (ev.valid),
    .ev_down  (ev.down),
    .clr      (clr),
    .ovf      (ovf),
    .sw_set   (sw_set),
    .sw_clr   (sw_clr),
    .flags    (flags),
    .cnt      (cnt),
    .aux      (aux),
    .top      (top),
    .topb     (topb)
);

// File: tb/quad_pulse_counter_tb.sv
module quad_pulse_counter_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  waddr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  raddr = '0;
    logic [15:0] rdata;
    logic        s0 = 1'b0;
    logic        s1 = 1'b0;
    logic [1:0]  irq;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pulse_counter u_dut (
        .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .s0(s0), .s1(s1), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] top;
        logic [15:0] init;
        logic        s1v;
        logic [7:0]  pulses;
        logic [15:0] exp_cnt;
        logic [15:0] exp_aux;
        logic [1:0]  exp_flags;
    } vec_t;

    // ctrl = mode | main<<2 | aux<<4 | dirpin<<6 | softdown<<7 | hyst<<8
    localparam vec_t VECS [9] = '{
        '{16'd118, 16'd10,  16'd0,  1'b0, 8'd5, 16'd5,  16'd0, 2'b00}, // R3 ext, up only
        '{16'd118, 16'd10,  16'd3,  1'b1, 8'd4, 16'd3,  16'd0, 2'b00}, // R5 up-only ignores down
        '{16'd66,  16'd10,  16'd2,  1'b1, 8'd4, 16'd9,  16'd4, 2'b10}, // R8 both, underflow
        '{16'd21,  16'd3,   16'd2,  1'b0, 8'd3, 16'd1,  16'd3, 2'b01}, // R7 ovs, overflow
        '{16'd99,  16'd100, 16'd50, 1'b0, 8'd6, 16'd56, 16'd0, 2'b00}, // R4 quad up
        '{16'd107, 16'd100, 16'd50, 1'b1, 8'd6, 16'd44, 16'd6, 2'b00}, // R4 quad down, R6 aux down
        '{16'd116, 16'd10,  16'd7,  1'b0, 8'd5, 16'd7,  16'd0, 2'b00}, // R2 disabled
        '{16'd94,  16'd10,  16'd9,  1'b0, 8'd4, 16'd9,  16'd4, 2'b00}, // R5 none, R6 aux up
        '{16'd178, 16'd5,   16'd1,  1'b0, 8'd3, 16'd4,  16'd0, 2'b10}  // R3 soft direction
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; waddr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        raddr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic pulse();
        @(negedge clk); s0 = 1'b1;
        repeat (5) @(negedge clk);
        s0 = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic glitch();
        @(negedge clk); s0 = 1'b1;
        @(negedge clk); s0 = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic step(input logic dir);
        @(negedge clk); s1 = dir;
        pulse();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd0, v); check("R1 ctrl", v, 32'h74);
        rd(4'd1, v); check("R1 cnt", v, 0);
        rd(4'd2, v); check("R1 aux", v, 0);
        rd(4'd3, v); check("R1 top", v, 16'hFFFF);
        rd(4'd4, v); check("R1 topb", v, 16'hFFFF);
        rd(4'd5, v); check("R1 flags", v, 0);
        check("R1 irq", int'(irq), 0);

        // table of modes and event selections
        for (int i = 0; i < 9; i++) begin
            wr(4'd0, 16'd116);
            wr(4'd9, 16'd1);
            wr(4'd7, 16'd3);
            wr(4'd3, VECS[i].top);
            wr(4'd1, VECS[i].init);
            @(negedge clk); s1 = VECS[i].s1v;
            wr(4'd0, VECS[i].ctrl);
            for (int p = 0; p < int'(VECS[i].pulses); p++) pulse();
            repeat (6) @(negedge clk);
            rd(4'd1, v); check($sformatf("R5 cnt vec %0d", i), v, int'(VECS[i].exp_cnt));
            rd(4'd2, v); check($sformatf("R6 aux vec %0d", i), v, int'(VECS[i].exp_aux));
            rd(4'd5, v); check($sformatf("R7 R8 flags vec %0d", i), v, int'(VECS[i].exp_flags));
        end

        // R3 glitch filter: oversampled drops, external counts
        @(negedge clk); s1 = 1'b0;
        wr(4'd0, 16'd21); wr(4'd9, 16'd1); wr(4'd3, 16'd100);
        glitch();
        rd(4'd1, v); check("R3 ovs glitch rejected", v, 0);
        wr(4'd0, 16'd118);
        glitch();
        rd(4'd1, v); check("R3 ext short pulse counted", v, 1);

        // R12 hysteresis in quadrature mode
        wr(4'd0, 16'd371); wr(4'd3, 16'd100);
        step(1'b0);
        wr(4'd1, 16'd50);
        step(1'b0); step(1'b0);
        rd(4'd1, v); check("R12 up run", v, 52);
        step(1'b1);
        rd(4'd1, v); check("R12 first reversal dropped", v, 52);
        step(1'b1);
        rd(4'd1, v); check("R12 second down counts", v, 51);
        step(1'b0); step(1'b0);
        rd(4'd1, v); check("R12 reversal back", v, 52);

        // R9 staged top
        @(negedge clk); s1 = 1'b0;
        wr(4'd0, 16'd118); wr(4'd9, 16'd1); wr(4'd7, 16'd3);
        wr(4'd3, 16'd5); wr(4'd4, 16'd2); wr(4'd1, 16'd4);
        pulse();
        rd(4'd3, v); check("R9 top held before wrap", v, 5);
        rd(4'd4, v); check("R9 topb staged", v, 2);
        pulse();
        rd(4'd1, v); check("R7 wrap to zero", v, 0);
        rd(4'd3, v); check("R9 top loaded at wrap", v, 2);
        pulse(); pulse(); pulse();
        rd(4'd1, v); check("R7 wraps at new top", v, 0);
        wr(4'd4, 16'd9); wr(4'd9, 16'd2);
        rd(4'd3, v); check("R9 load command", v, 9);

        // R10 clear command
        wr(4'd0, 16'd86); wr(4'd3, 16'd50);
        pulse(); pulse();
        rd(4'd2, v); check("R6 aux before clear", v, 2);
        wr(4'd9, 16'd1);
        rd(4'd1, v); check("R10 cnt cleared", v, 0);
        rd(4'd2, v); check("R10 aux cleared", v, 0);
        rd(4'd3, v); check("R10 top cleared", v, 0);

        // R11 flags, set/clear and mask
        wr(4'd0, 16'd116);
        wr(4'd7, 16'd3); wr(4'd8, 16'd2);
        wr(4'd6, 16'd1);
        rd(4'd5, v); check("R11 sw set", v, 1);
        check("R11 masked irq", int'(irq), 0);
        wr(4'd6, 16'd2);
        check("R11 enabled irq", int'(irq), 2);
        wr(4'd7, 16'd2);
        rd(4'd5, v); check("R11 sw clear", v, 1);
        check("R11 irq after clear", int'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule